// File: doc/BRIEF.md
# Inter-Thread Ring Queue Registers

This block joins a set of logical processors into a ring of hardware queues so that threads can hand values to one another at the register level. Each processor owns one outgoing queue toward its successor and reads from the queue owned by its predecessor. The last processor's queue feeds processor 0.

Each processor has a queue mode that is switched on and off by dedicated control pulses. While the mode is on, two ordinary register numbers change meaning for that processor. A read of the receive register number pops the incoming queue, and a write to the send register number pushes into the outgoing queue. While the mode is off, or for any other register number, the access is reported as a normal register-bank access and the queues are left alone.

The empty and full flags of each queue serve directly as scoreboard interlocks. A pop from an empty queue reports a stall, and so does a push into a full queue. The stalled access then has to be retried. Every response is registered and appears one clock after the request.

Top module: `thread_ring_queues`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every `mode_o` bit is 0, every `q_empty_o` bit is 1, every `q_full_o` bit is 0, and all read and write response bits are 0.
- R2: A pulse on `mode_on_i[p]` sets `mode_o[p]` one cycle later. A pulse on `mode_off_i[p]` clears it. When both are pulsed in the same cycle, the mode is cleared.
- R3: A read or write is redirected only if the processor's mode is on and the register number is the receive number (default 30) or the send number (default 31). Any other access gives `rd_queue_o`/`wr_queue_o` = 0 in the next cycle, and every queue keeps its contents.
- R4: A redirected write by processor p to a queue that is not full appends `wr_data` to queue p, which feeds processor (p+1) mod N. In the next cycle it gives `wr_queue_o[p]`=1 and `wr_stall_o[p]`=0.
- R5: A redirected read by processor p from a non-empty queue pops the oldest entry of queue (p-1) mod N. In the next cycle that value is on `rd_data_o[p]` with `rd_queue_o[p]`=1 and `rd_stall_o[p]`=0. Values leave each queue in the order they were written.
- R6: A redirected read from an empty queue gives `rd_stall_o[p]`=1 in the next cycle and removes nothing.
- R7: Each queue holds DEPTH entries (default 4). A redirected write to a full queue gives `wr_stall_o[p]`=1 in the next cycle, and its data is not stored.
- R8: In every cycle, `q_empty_o[k]` and `q_full_o[k]` give whether queue k holds zero or DEPTH entries after the previous clock edge.
- R9: When a push and a pop act on the same queue in one cycle, both succeed and the occupancy stays the same.
- R10: Pulsing `mode_off_i[p]` empties queue p (the outgoing queue) in the next cycle and leaves queue (p-1) mod N unchanged. Responses in that cycle are computed from the state before the clear.
- R11: The ring closes: data written by processor N-1 is read by processor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_on_i | input | N_PROC | Per-processor pulse that turns queue mode on |
| mode_off_i | input | N_PROC | Per-processor pulse that turns queue mode off and empties the outgoing queue |
| rd_valid_i | input | N_PROC | Per-processor register read request |
| rd_reg_i | input | N_PROC*REG_W | Register number read by each processor |
| wr_valid_i | input | N_PROC | Per-processor register write request |
| wr_reg_i | input | N_PROC*REG_W | Register number written by each processor |
| wr_data_i | input | N_PROC*DATA_W | Write data from each processor |
| mode_o | output | N_PROC | Current queue mode of each processor |
| rd_queue_o | output | N_PROC | Previous read was taken by the incoming queue (not the bank) |
| rd_stall_o | output | N_PROC | Previous queue read found the queue empty |
| rd_data_o | output | N_PROC*DATA_W | Data popped by the previous successful queue read |
| wr_queue_o | output | N_PROC | Previous write was taken by the outgoing queue (not the bank) |
| wr_stall_o | output | N_PROC | Previous queue write found the queue full |
| q_empty_o | output | N_PROC | Empty flag of each processor's outgoing queue |
| q_full_o | output | N_PROC | Full flag of each processor's outgoing queue |

## Verification
The hardest situation to reach is a push and a pop on the same queue in the same cycle at a known occupancy. Reaching it takes two neighbouring processors acting together, with the writer's queue neither empty nor full. Proving that the occupancy held takes a further write that must fill the queue after exactly one entry. Equally awkward is a disable pulse on a processor whose outgoing and incoming queues both hold data, because the result must show one queue cleared and the other intact. The bench builds both cases with directed sequences. It then runs a long random phase with mixed register numbers and occasional mode toggles, compared every clock against a queue-based reference model.

// File: rtl/trq_pkg.sv
package trq_pkg;

  localparam int unsigned TRQ_NPROC_DEF = 4;
  localparam int unsigned TRQ_DEPTH_DEF = 4;
  localparam int unsigned TRQ_DATA_DEF  = 32;
  localparam int unsigned TRQ_REGW_DEF  = 5;

  // neighbour index on the ring
  function automatic int unsigned ring_prev(input int unsigned k, input int unsigned n);
    return (k == 0) ? n - 1 : k - 1;
  endfunction

  function automatic int unsigned ring_next(input int unsigned k, input int unsigned n);
    return (k == n - 1) ? 0 : k + 1;
  endfunction

endpackage

// File: rtl/trq_fifo.sv
module trq_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              empty_o,
  output logic              full_o
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt, cnt_nxt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cnt_nxt = cnt;
    if (push && !pop)      cnt_nxt = cnt + 1'b1;
    else if (pop && !push) cnt_nxt = cnt - 1'b1;
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) store[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop) rdata <= store[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      empty_o <= 1'b1;
      full_o  <= 1'b0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      cnt     <= cnt_nxt;
      empty_o <= (cnt_nxt == '0);
      full_o  <= (cnt_nxt == CNT_FULL);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full_o); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty_o); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(empty_o && full_o)); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst) clr |=> (empty_o && !full_o)); // R10
  AST_PUSHPOP_STEADY: assert property (@(posedge clk) disable iff (rst) (push && pop && !clr) |=> $stable(cnt)); // R9

endmodule

// File: rtl/trq_port.sv
module trq_port #(
  parameter int unsigned         REG_W  = 5,
  parameter logic [REG_W-1:0]    RX_REG = 5'd30,
  parameter logic [REG_W-1:0]    TX_REG = 5'd31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_on_i,
  input  logic             mode_off_i,
  input  logic             rd_valid_i,
  input  logic [REG_W-1:0] rd_reg_i,
  input  logic             wr_valid_i,
  input  logic [REG_W-1:0] wr_reg_i,
  input  logic             in_empty_i,
  input  logic             out_full_i,
  output logic             pop_o,
  output logic             push_o,
  output logic             mode_o,
  output logic             rd_queue_o,
  output logic             rd_stall_o,
  output logic             wr_queue_o,
  output logic             wr_stall_o
);

  logic mode_q;
  logic hit_rd, hit_wr;

  assign hit_rd = mode_q && rd_valid_i && (rd_reg_i == RX_REG);
  assign hit_wr = mode_q && wr_valid_i && (wr_reg_i == TX_REG);

  // full/empty flags act as the interlock
  assign pop_o  = hit_rd && !in_empty_i;
  assign push_o = hit_wr && !out_full_i;
  assign mode_o = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= 1'b0;
      rd_queue_o <= 1'b0;
      rd_stall_o <= 1'b0;
      wr_queue_o <= 1'b0;
      wr_stall_o <= 1'b0;
    end else begin
      if (mode_off_i)     mode_q <= 1'b0;
      else if (mode_on_i) mode_q <= 1'b1;
      rd_queue_o <= hit_rd;
      rd_stall_o <= hit_rd && in_empty_i;
      wr_queue_o <= hit_wr;
      wr_stall_o <= hit_wr && out_full_i;
    end
  end

  AST_BANK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) !mode_q |=> (!rd_queue_o && !wr_queue_o)); // R3
  AST_RD_STALL_ON_EMPTY: assert property (@(posedge clk) disable iff (rst) rd_stall_o |-> $past(in_empty_i)); // R6
  AST_WR_STALL_ON_FULL: assert property (@(posedge clk) disable iff (rst) wr_stall_o |-> $past(out_full_i)); // R7

endmodule

// File: rtl/thread_ring_queues.sv
module thread_ring_queues #(
  parameter int unsigned      N_PROC = trq_pkg::TRQ_NPROC_DEF,
  parameter int unsigned      DEPTH  = trq_pkg::TRQ_DEPTH_DEF,
  parameter int unsigned      DATA_W = trq_pkg::TRQ_DATA_DEF,
  parameter int unsigned      REG_W  = trq_pkg::TRQ_REGW_DEF,
  parameter logic [REG_W-1:0] RX_REG = 5'd30,
  parameter logic [REG_W-1:0] TX_REG = 5'd31
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_PROC-1:0]        mode_on_i,
  input  logic [N_PROC-1:0]        mode_off_i,
  input  logic [N_PROC-1:0]        rd_valid_i,
  input  logic [N_PROC*REG_W-1:0]  rd_reg_i,
  input  logic [N_PROC-1:0]        wr_valid_i,
  input  logic [N_PROC*REG_W-1:0]  wr_reg_i,
  input  logic [N_PROC*DATA_W-1:0] wr_data_i,
  output logic [N_PROC-1:0]        mode_o,
  output logic [N_PROC-1:0]        rd_queue_o,
  output logic [N_PROC-1:0]        rd_stall_o,
  output logic [N_PROC*DATA_W-1:0] rd_data_o,
  output logic [N_PROC-1:0]        wr_queue_o,
  output logic [N_PROC-1:0]        wr_stall_o,
  output logic [N_PROC-1:0]        q_empty_o,
  output logic [N_PROC-1:0]        q_full_o
);

  logic [N_PROC-1:0] pop_w;   // indexed by reading processor
  logic [N_PROC-1:0] push_w;  // indexed by writing processor / queue

  for (genvar k = 0; k < N_PROC; k++) begin : g_node
    localparam int unsigned PRV = trq_pkg::ring_prev(k, N_PROC);
    localparam int unsigned NXT = trq_pkg::ring_next(k, N_PROC);

    // queue k: written by processor k, read by processor NXT
    trq_fifo #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
    ) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .clr     (mode_off_i[k]),
      .push    (push_w[k]),
      .pop     (pop_w[NXT]),
      .wdata   (wr_data_i[k*DATA_W +: DATA_W]),
      .rdata   (rd_data_o[NXT*DATA_W +: DATA_W]),
      .empty_o (q_empty_o[k]),
      .full_o  (q_full_o[k])
    );

    trq_port #(
      .REG_W  (REG_W),
      .RX_REG (RX_REG),
      .TX_REG (TX_REG)
    ) u_port (
      .clk        (clk),
      .rst        (rst),
      .mode_on_i  (mode_on_i[k]),
      .mode_off_i (mode_off_i[k]),
      .rd_valid_i (rd_valid_i[k]),
      .rd_reg_i   (rd_reg_i[k*REG_W +: REG_W]),
      .wr_valid_i (wr_valid_i[k]),
      .wr_reg_i   (wr_reg_i[k*REG_W +: REG_W]),
      .in_empty_i (q_empty_o[PRV]),
      .out_full_i (q_full_o[k]),
      .pop_o      (pop_w[k]),
      .push_o     (push_w[k]),
      .mode_o     (mode_o[k]),
      .rd_queue_o (rd_queue_o[k]),
      .rd_stall_o (rd_stall_o[k]),
      .wr_queue_o (wr_queue_o[k]),
      .wr_stall_o (wr_stall_o[k])
    );
  end

endmodule

// File: tb/thread_ring_queues_test.sv
`timescale 1ns/1ps
module thread_ring_queues_test;

  localparam int N  = 4;
  localparam int D  = 4;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam logic [RW-1:0] RX = 5'd30;
  localparam logic [RW-1:0] TX = 5'd31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    mode_on, mode_off, rd_v, wr_v;
  logic [N*RW-1:0] rd_r, wr_r;
  logic [N*DW-1:0] wr_d;
  logic [N-1:0]    mode_o, rdq_o, rds_o, wrq_o, wrs_o, qe_o, qf_o;
  logic [N*DW-1:0] rdd_o;

  always #5 clk = ~clk;

  thread_ring_queues #(.N_PROC(N), .DEPTH(D), .DATA_W(DW), .REG_W(RW), .RX_REG(RX), .TX_REG(TX)) uut (
    .clk(clk), .rst(rst), .mode_on_i(mode_on), .mode_off_i(mode_off),
    .rd_valid_i(rd_v), .rd_reg_i(rd_r), .wr_valid_i(wr_v), .wr_reg_i(wr_r), .wr_data_i(wr_d),
    .mode_o(mode_o), .rd_queue_o(rdq_o), .rd_stall_o(rds_o), .rd_data_o(rdd_o),
    .wr_queue_o(wrq_o), .wr_stall_o(wrs_o), .q_empty_o(qe_o), .q_full_o(qf_o));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  bit              m_mode [N];
  logic [DW-1:0]   mq [N][$];
  bit              e_rdq [N], e_rds [N], e_wrq [N], e_wrs [N];
  logic [DW-1:0]   e_data [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit pop_k [N];
    bit push_k [N];
    if (rst) begin
      for (int p = 0; p < N; p++) begin
        m_mode[p] = 0; mq[p].delete();
        e_rdq[p] = 0; e_rds[p] = 0; e_wrq[p] = 0; e_wrs[p] = 0;
      end
    end else begin
      for (int p = 0; p < N; p++) begin
        int pr;
        bit rq, wq;
        pr = (p + N - 1) % N;
        rq = m_mode[p] && rd_v[p] && (rd_r[p*RW +: RW] == RX);
        wq = m_mode[p] && wr_v[p] && (wr_r[p*RW +: RW] == TX);
        e_rdq[p] = rq;
        e_rds[p] = rq && (mq[pr].size() == 0);
        e_wrq[p] = wq;
        e_wrs[p] = wq && (mq[p].size() == D);
        pop_k[pr] = rq && (mq[pr].size() != 0);
        push_k[p] = wq && (mq[p].size() != D);
        if (pop_k[pr]) e_data[p] = mq[pr][0];
      end
      for (int k = 0; k < N; k++) begin
        if (pop_k[k]) void'(mq[k].pop_front());
        if (push_k[k]) mq[k].push_back(wr_d[k*DW +: DW]);
        if (mode_off[k]) mq[k].delete();
        if (mode_off[k]) m_mode[k] = 0;
        else if (mode_on[k]) m_mode[k] = 1;
      end
    end
  end

  task automatic compare_all();
    for (int p = 0; p < N; p++) begin
      chk(mode_o[p] == m_mode[p], "R2", $sformatf("mode[%0d]", p), mode_o[p], m_mode[p]);
      chk(qe_o[p] == (mq[p].size() == 0), "R8", $sformatf("empty[%0d]", p), qe_o[p], mq[p].size() == 0);
      chk(qf_o[p] == (mq[p].size() == D), "R8", $sformatf("full[%0d]", p), qf_o[p], mq[p].size() == D);
      chk(rdq_o[p] == e_rdq[p], "R3", $sformatf("rd_queue[%0d]", p), rdq_o[p], e_rdq[p]);
      chk(wrq_o[p] == e_wrq[p], "R3", $sformatf("wr_queue[%0d]", p), wrq_o[p], e_wrq[p]);
      chk(rds_o[p] == e_rds[p], "R6", $sformatf("rd_stall[%0d]", p), rds_o[p], e_rds[p]);
      chk(wrs_o[p] == e_wrs[p], "R7", $sformatf("wr_stall[%0d]", p), wrs_o[p], e_wrs[p]);
      if (e_rdq[p] && !e_rds[p])
        chk(rdd_o[p*DW +: DW] == e_data[p], "R5", $sformatf("rd_data[%0d]", p), rdd_o[p*DW +: DW], e_data[p]);
    end
  endtask

  task automatic idle();
    mode_on = '0; mode_off = '0; rd_v = '0; wr_v = '0;
    rd_r = '0; wr_r = '0; wr_d = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (!rst) compare_all();
    idle();
  endtask

  task automatic put(input int p, input logic [RW-1:0] r, input logic [DW-1:0] d);
    wr_v[p] = 1'b1; wr_r[p*RW +: RW] = r; wr_d[p*DW +: DW] = d;
  endtask

  task automatic get(input int p, input logic [RW-1:0] r);
    rd_v[p] = 1'b1; rd_r[p*RW +: RW] = r;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    chk(0, "WATCHDOG", "timeout", 0, 1);
    finish_up();
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(mode_o == '0, "R1", "mode after reset", mode_o, 0);
    chk(qe_o == '1 && qf_o == '0, "R1", "flags after reset", {qe_o, qf_o}, {4'hf, 4'h0});
    chk((rdq_o | rds_o | wrq_o | wrs_o) == '0, "R1", "responses after reset", rdq_o | wrq_o, 0);

    // R3: mode off, send register goes to bank
    put(0, TX, 32'hDEAD0000); cyc();
    chk(wrq_o[0] == 0 && qe_o[0] == 1, "R3", "write while mode off", {wrq_o[0], qe_o[0]}, 2'b01);

    // R2: enable all
    mode_on = '1; cyc();
    chk(mode_o == '1, "R2", "mode on", mode_o, 4'hf);

    // R4 / R7: fill queue 0
    for (int i = 0; i < D; i++) begin
      put(0, TX, 32'hA1 + i); cyc();
      chk(wrq_o[0] && !wrs_o[0], "R4", "push accepted", {wrq_o[0], wrs_o[0]}, 2'b10);
    end
    chk(qf_o[0] == 1, "R7", "queue0 full after DEPTH pushes", qf_o[0], 1);
    put(0, TX, 32'hBAD); cyc();
    chk(wrs_o[0] == 1, "R7", "push into full stalls", wrs_o[0], 1);

    // R5 / R6: drain in order at processor 1
    for (int i = 0; i < D; i++) begin
      get(1, RX); cyc();
      chk(rdd_o[1*DW +: DW] == 32'hA1 + i, "R5", "fifo order", rdd_o[1*DW +: DW], 32'hA1 + i);
    end
    get(1, RX); cyc();
    chk(rds_o[1] == 1, "R6", "pop empty stalls", rds_o[1], 1);

    // R11: ring wrap 3 -> 0
    put(3, TX, 32'h3300); cyc();
    get(0, RX); cyc();
    chk(rdq_o[0] && !rds_o[0] && rdd_o[0 +: DW] == 32'h3300, "R11", "wrap data", rdd_o[0 +: DW], 32'h3300);

    // R9: simultaneous push/pop at occupancy 3
    for (int i = 0; i < 3; i++) begin put(1, TX, 32'h100 + i); cyc(); end
    put(1, TX, 32'h200); get(2, RX); cyc();
    chk(rdd_o[2*DW +: DW] == 32'h100 && !qf_o[1] && !qe_o[1], "R9", "push+pop", rdd_o[2*DW +: DW], 32'h100);
    put(1, TX, 32'h201); cyc();
    chk(qf_o[1] == 1, "R9", "occupancy held, full after one more", qf_o[1], 1);

    // R3: other register number while on
    put(2, 5'd5, 32'h55); get(3, 5'd7); cyc();
    chk(!wrq_o[2] && !rdq_o[3] && qe_o[2], "R3", "unmapped register", {wrq_o[2], rdq_o[3]}, 0);

    // R10: disable 2 with outgoing and incoming queues filled
    put(2, TX, 32'h77); cyc();
    mode_off[2] = 1'b1; cyc();
    chk(qe_o[2] == 1 && qf_o[1] == 1, "R10", "own cleared, incoming kept", {qe_o[2], qf_o[1]}, 2'b11);
    get(2, RX); cyc();
    chk(rdq_o[2] == 0 && qf_o[1] == 1, "R3", "disabled read uses bank", rdq_o[2], 0);
    // R2: on and off together -> off
    mode_on[2] = 1'b1; mode_off[2] = 1'b1; cyc();
    chk(mode_o[2] == 0, "R2", "off wins", mode_o[2], 0);

    // random phase
    mode_on = '1; cyc();
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < N; p++) begin
        logic [RW-1:0] ra, wa;
        int s;
        s = $urandom % 4;
        ra = (s == 0) ? 5'd5 : (s == 1) ? TX : RX;
        s = $urandom % 4;
        wa = (s == 0) ? 5'd9 : (s == 1) ? RX : TX;
        if ($urandom % 2) get(p, ra);
        if ($urandom % 2) put(p, wa, $urandom);
        if ($urandom % 64 == 0) mode_off[p] = 1'b1;
        if ($urandom % 16 == 0) mode_on[p] = 1'b1;
      end
      cyc();
    end
    finish_up();
  end

endmodule